// File: doc/BRIEF.md
# Layer-1 Indication Code Status Register

This block is the receive-side status register of a layer-1 line interface controller. A line decoder outside the block hands it each received 4-bit indication code and each received 4-bit S-channel code, both with a one-cycle valid strobe. The block keeps the indication codes in a two-entry queue and shows the oldest unread one in the low nibble of an 8-bit read word. It raises a change flag for each of the two code streams, and it drives a level interrupt while either flag is set.

Software reads the word through a plain read strobe. Reading this register retires the code it has just returned. The S-channel flag is cleared only by the read strobe of the separate S-channel register. A slave serial-bus mode input suppresses the S-channel flag. A software reset bit holds the whole block in its reset state for as long as it is 1, and reads return zero during that time.

Top module: `l1_ind_status`

## Requirements
- R1: After hardware reset the read word is 0x0F and the interrupt is 0.
- R2: Read word layout: bit 7 is the S-channel change flag, bit 6 is the indication change flag, bits 5:4 read 0, and bits 3:0 hold the oldest unread indication code.
- R3: A valid indication code that differs from the most recently queued code sets bit 6 and, if the queue was empty, appears in bits 3:0 from the next cycle on.
- R4: A valid indication code equal to the most recently queued code leaves the read word unchanged.
- R5: A second new code that arrives while one is unread is queued. A read returns the oldest code and then advances to the queued one. Bit 6 stays 1 until a read finds no queued code.
- R6: A new code that arrives while both entries are full overwrites the queued (newest) entry and keeps the oldest.
- R7: A read of this register that finds no queued code clears bit 6 and does not change bit 7.
- R8: A valid S-channel code that differs from the previous one sets bit 7. Only the S-channel read strobe clears it, and a change in the same cycle as that strobe leaves it set.
- R9: While slave mode is 1, bit 7 reads 0 and is not set. Indication codes, including 4'b1111 (idle) and 4'b0111 (power-up), are queued as in R3.
- R10: While the software reset input is 1, the read word and the interrupt are 0 and all state returns to reset. Once the input returns to 0, the read word is 0x0F.
- R11: The interrupt output is 1 exactly when bit 7 or bit 6 of the read word is 1.
- R12: When a read of this register and a new indication code fall in the same cycle, the read returns the pre-edge word, the read is applied first, and the new code is then queued behind the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software reset bit, holds the block in reset while 1 |
| slave_mode | input | 1 | Slave serial-bus mode, suppresses the S-channel flag |
| ind_vld | input | 1 | Strobe: received indication code valid |
| ind_code | input | 4 | Received indication code |
| sch_vld | input | 1 | Strobe: received S-channel code valid |
| sch_code | input | 4 | Received S-channel code |
| rd_ind | input | 1 | Read strobe of this register |
| rd_sch | input | 1 | Read strobe of the S-channel register |
| rd_data | output | 8 | Read word |
| irq | output | 1 | Level interrupt, OR of the two change flags |

## Verification
Two events can land in the same cycle: a read of this register and the arrival of a new indication code. The bench provokes this with the queue empty, with one code unread and with both entries full. In each case it checks that the read returned the pre-edge word and that the next word shows the read applied before the new code was queued. The S-channel flag gets the same treatment: a new S-channel change is driven in the cycle of its clearing read, and the flag must still be set afterwards.

// File: rtl/l1_ind_status.sv
module l1_ind_status #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              slave_mode,
  input  logic              ind_vld,
  input  logic [CODE_W-1:0] ind_code,
  input  logic              sch_vld,
  input  logic [CODE_W-1:0] sch_code,
  input  logic              rd_ind,
  input  logic              rd_sch,
  output logic [7:0]        rd_data,
  output logic              irq
);
  localparam int PAD_W = 6 - CODE_W;
  localparam logic [CODE_W-1:0] IDLE = '1;

  logic [CODE_W-1:0] cur, q, sch_last;
  logic              icc, qv, sch_flag;
  logic [CODE_W-1:0] n_cur, n_q;
  logic              n_icc, n_qv;

  wire [CODE_W-1:0] last    = qv ? q : cur;
  wire              ind_new = ind_vld && (ind_code != last);
  wire              sch_new = sch_vld && (sch_code != sch_last);

  // read retires first, then a new code is queued behind the result
  always_comb begin
    n_cur = cur; n_q = q; n_qv = qv; n_icc = icc;
    if (rd_ind) begin
      if (qv) begin n_cur = q; n_qv = 1'b0; end
      else n_icc = 1'b0;
    end
    if (ind_new) begin
      if (!n_icc) begin n_cur = ind_code; n_icc = 1'b1; end
      else begin n_q = ind_code; n_qv = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= IDLE; q <= IDLE; qv <= 1'b0; icc <= 1'b0;
      sch_last <= '0; sch_flag <= 1'b0;
    end else if (soft_rst) begin
      cur <= IDLE; q <= IDLE; qv <= 1'b0; icc <= 1'b0;
      sch_last <= '0; sch_flag <= 1'b0;
    end else begin
      cur <= n_cur; q <= n_q; qv <= n_qv; icc <= n_icc;
      if (sch_vld) sch_last <= sch_code;
      if (slave_mode)   sch_flag <= 1'b0;
      else if (sch_new) sch_flag <= 1'b1;
      else if (rd_sch)  sch_flag <= 1'b0;
    end
  end

  wire sch_vis = sch_flag & ~slave_mode;
  assign rd_data = soft_rst ? 8'h00 : {sch_vis, icc, {PAD_W{1'b0}}, cur};
  assign irq     = ~soft_rst & (icc | sch_vis);

  assert_soft_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst ##1 !soft_rst |-> rd_data == {2'b00, {PAD_W{1'b0}}, IDLE});

  assert_irq_or_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[7] | rd_data[6]));

  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    slave_mode && $past(slave_mode) |-> !sch_flag);

  assert_sch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    sch_flag && !rd_sch && !slave_mode |=> sch_flag);

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    rd_ind && icc && !qv && !ind_vld |=> !icc);

  assert_queue_advance_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    rd_ind && qv && !ind_vld |=> icc && cur == $past(q));

  assert_same_code_R4: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ind_vld && ind_code == last && !rd_ind |=> $stable(rd_data[6:0]));
endmodule

// File: tb/tb_l1_ind_status.sv
module tb_l1_ind_status;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, slave_mode = 1'b0;
  logic ind_vld = 1'b0, sch_vld = 1'b0, rd_ind = 1'b0, rd_sch = 1'b0;
  logic [3:0] ind_code = '0, sch_code = '0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  l1_ind_status dut (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .slave_mode(slave_mode),
    .ind_vld(ind_vld), .ind_code(ind_code), .sch_vld(sch_vld), .sch_code(sch_code),
    .rd_ind(rd_ind), .rd_sch(rd_sch), .rd_data(rd_data), .irq(irq));

  // fields: slave, ind_vld, ind_code, sch_vld, sch_code, rd_ind, rd_sch, expected pre-edge word
  localparam logic [20:0] VEC [0:30] = '{
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,1'b0, 8'h0F}, // R1 idle
    {1'b0, 1'b1,4'h3, 1'b0,4'h0, 1'b0,1'b0, 8'h0F}, // R3 new code
    {1'b0, 1'b1,4'h3, 1'b0,4'h0, 1'b0,1'b0, 8'h43}, // R4 same code
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,1'b0, 8'h43}, // R4 unchanged
    {1'b0, 1'b1,4'h5, 1'b0,4'h0, 1'b0,1'b0, 8'h43}, // R5 queued
    {1'b0, 1'b1,4'h9, 1'b0,4'h0, 1'b0,1'b0, 8'h43}, // R6 overwrite newest
    {1'b0, 1'b1,4'h9, 1'b0,4'h0, 1'b0,1'b0, 8'h43}, // R4 equal to queued
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,1'b0, 8'h43}, // R5 read oldest
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,1'b0, 8'h49}, // R6 kept 9, R7 last read
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,1'b0, 8'h09}, // R7 cleared
    {1'b0, 1'b0,4'h0, 1'b1,4'h6, 1'b0,1'b0, 8'h09}, // R8 S change
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,1'b0, 8'h89}, // R8 set, R2 layout
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,1'b0, 8'h89}, // R7 bit 7 untouched
    {1'b0, 1'b0,4'h0, 1'b1,4'hA, 1'b0,1'b1, 8'h89}, // R8 change with clear
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,1'b1, 8'h89}, // R8 still set
    {1'b0, 1'b0,4'h0, 1'b1,4'hA, 1'b0,1'b0, 8'h09}, // R8 cleared, same code
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,1'b0, 8'h09}, // R8 no set on same
    {1'b0, 1'b1,4'h2, 1'b0,4'h0, 1'b1,1'b0, 8'h09}, // R12 empty queue
    {1'b0, 1'b1,4'h4, 1'b0,4'h0, 1'b1,1'b0, 8'h42}, // R12 one unread
    {1'b0, 1'b1,4'h1, 1'b0,4'h0, 1'b0,1'b0, 8'h44}, // R12 result, queue 1
    {1'b0, 1'b1,4'h8, 1'b0,4'h0, 1'b1,1'b0, 8'h44}, // R12 full queue
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,1'b0, 8'h41}, // R12 advanced to 1
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,1'b0, 8'h48}, // R12 8 queued behind
    {1'b1, 1'b0,4'h0, 1'b1,4'h3, 1'b0,1'b0, 8'h08}, // R9 S change in slave
    {1'b1, 1'b1,4'h7, 1'b0,4'h0, 1'b0,1'b0, 8'h08}, // R9 power-up code
    {1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b1,1'b0, 8'h47}, // R9 captured
    {1'b1, 1'b1,4'hF, 1'b0,4'h0, 1'b0,1'b0, 8'h07}, // R9 idle code
    {1'b1, 1'b0,4'h0, 1'b1,4'h5, 1'b0,1'b0, 8'h4F}, // R9 captured
    {1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b0,1'b0, 8'h4F}, // R9 bit 7 stays 0
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,1'b0, 8'h4F}, // R7
    {1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,1'b0, 8'h0F}  // R2
  };

  task automatic check(input string req, input logic [7:0] exp_d);
    checks++;
    if (rd_data !== exp_d) begin
      fails++;
      $display("FAIL %s rd_data=%h expected=%h", req, rd_data, exp_d);
    end
    checks++;
    if (irq !== (exp_d[7] | exp_d[6])) begin
      fails++;
      $display("FAIL %s irq=%b expected=%b", req, irq, exp_d[7] | exp_d[6]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD*20000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset", 8'h0F);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 31; i++) begin
      @(negedge clk);
      {slave_mode, ind_vld, ind_code, sch_vld, sch_code, rd_ind, rd_sch} = VEC[i][20:8];
      #1 check($sformatf("vector %0d", i), VEC[i][7:0]);
    end
    // R10 software reset
    @(negedge clk);
    {slave_mode, ind_vld, ind_code, sch_vld, sch_code, rd_ind, rd_sch} = {1'b0, 1'b1, 4'h3, 1'b1, 4'h6, 2'b00};
    @(negedge clk);
    {ind_vld, sch_vld} = 2'b00;
    #1 check("R10 before soft reset", 8'hC3);
    @(negedge clk);
    soft_rst = 1'b1;
    #1 check("R10 held", 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      {ind_vld, ind_code, sch_vld, sch_code} = {1'b1, 4'h5, 1'b1, 4'h9};
      #1 check("R10 held with input", 8'h00);
    end
    @(negedge clk);
    {ind_vld, sch_vld} = 2'b00;
    soft_rst = 1'b0;
    #1 check("R10 released", 8'h0F);
    @(negedge clk);
    #1 check("R10 inputs ignored", 8'h0F);
    summary();
  end
endmodule